// File: doc/BRIEF.md
# Fixed-Point Euler Integrator Engine

This block numerically integrates a fixed second-order recurrence with forward-Euler steps. It accepts one operand set (start point x, state y, derivative u, step dx and end bound a) on a valid/ready input channel. It then iterates until x reaches the bound and returns the final y on a valid/ready output channel. All values are signed fixed point with FRAC fraction bits, Q8.8 by default. A single shared multiplier is sequenced by a small controller, so every loop pass takes a fixed number of cycles.

The input side applies back-pressure by holding `in_ready` low from acceptance until the result has been handed over. An offer made during that time is not taken. It stays pending and is accepted once the engine is idle again. The output side holds `out_valid` and `y_out` unchanged for as long as `out_ready` is low. The result is consumed on the first rising edge with both `out_valid` and `out_ready` high.

Top module: `euler_solver`

## Requirements
- R1: While reset is low and after its release, `in_ready` is 1, and `out_valid` and `busy` are 0.
- R2: On a rising edge with `in_valid` and `in_ready` both high, x, y, u, dx and a are captured as two's complement signed values with FRAC fraction bits (8 by default). Only this capture changes the stored dx and a.
- R3: Each pass sets the next x to x + dx, modulo 2^W.
- R4: Each product is formed at full precision, shifted right arithmetically by FRAC and kept to its low W bits. From the values held before the pass, p = u·dx, q = x·p and r = y·dx are formed. The pass then sets u to u − 3q − 3r and y to y + p, modulo 2^W.
- R5: After each pass the loop repeats while the new x is less than a (signed compare). At least one pass is always made, even if x already equals or exceeds a.
- R6: Every pass takes exactly 4 cycles. `out_valid` first reads high 4·N cycles after the acceptance edge, where N is the number of passes.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `y_out` stays unchanged.
- R8: From acceptance until the result is consumed, `in_ready` is 0. Any `in_valid` offer in that time is not taken and does not alter the result being computed.
- R9: `busy` is 1 from the acceptance edge until the edge on which the result is consumed, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand set offered |
| in_ready | output | 1 | Engine idle and able to take an operand set |
| x_in | input | W | Start value of x |
| y_in | input | W | Start value of y |
| u_in | input | W | Start value of u |
| dx_in | input | W | Step size |
| a_in | input | W | Upper bound for x |
| out_valid | output | 1 | Final y available |
| out_ready | input | 1 | Downstream takes the result |
| y_out | output | W | Final y |
| busy | output | 1 | An integration is in progress or its result is pending |

## Verification
The result of an operand set is due exactly 4·N cycles after its acceptance edge, where N is the pass count that the bench's own reference loop gives. The driver records the cycle of acceptance together with the expected y and N in a scoreboard queue. The monitor flags any result whose first visible cycle differs from that record. Outputs are sampled on falling edges, one half-cycle after the register edge that moves them. During deliberate output stalls the monitor compares `y_out` each cycle against its first value. During busy periods the bench offers other operand sets and checks that `in_ready` stays low and that the queued result still matches.

// File: rtl/euler_pkg.sv
package euler_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_UD   = 3'd1,
    PH_XUD  = 3'd2,
    PH_YD   = 3'd3,
    PH_UPD  = 3'd4,
    PH_DONE = 3'd5
  } phase_t;
endpackage

// File: rtl/euler_mul.sv
module euler_mul #(
  parameter int W    = 16,
  parameter int FRAC = 8
) (
  input  logic signed [W-1:0] op_a,
  input  logic signed [W-1:0] op_b,
  output logic signed [W-1:0] prod
);
  localparam int PW = W + FRAC;

  logic signed [PW-1:0] ext_a, ext_b, full;

  assign ext_a = PW'(op_a);
  assign ext_b = PW'(op_b);
  assign full  = ext_a * ext_b;

  generate
    if (FRAC == 0) begin : g_int
      assign prod = W'(full);
    end else begin : g_frac
      assign prod = W'(full >>> FRAC);
    end
  endgenerate
endmodule

// File: rtl/euler_ctrl.sv
module euler_ctrl
  import euler_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   in_valid,
  input  logic   out_ready,
  input  logic   cont,
  output phase_t phase,
  output logic   load,
  output logic   in_ready,
  output logic   out_valid,
  output logic   busy
);
  phase_t ph_q, ph_d;

  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      PH_IDLE: if (in_valid) ph_d = PH_UD;
      PH_UD:   ph_d = PH_XUD;
      PH_XUD:  ph_d = PH_YD;
      PH_YD:   ph_d = PH_UPD;
      PH_UPD:  ph_d = cont ? PH_UD : PH_DONE;
      PH_DONE: if (out_ready) ph_d = PH_IDLE;
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ph_q <= PH_IDLE;
    else        ph_q <= ph_d;
  end

  assign phase     = ph_q;
  assign in_ready  = (ph_q == PH_IDLE);
  assign load      = in_ready && in_valid;
  assign out_valid = (ph_q == PH_DONE);
  assign busy      = !in_ready;

  // R6: a pass walks through its four steps in a fixed order
  a_r6_step_ud: assert property (@(posedge clk) disable iff (!rst_n)
    ph_q == PH_UD |=> ph_q == PH_XUD);
  a_r6_step_xud: assert property (@(posedge clk) disable iff (!rst_n)
    ph_q == PH_XUD |=> ph_q == PH_YD);
  a_r6_step_yd: assert property (@(posedge clk) disable iff (!rst_n)
    ph_q == PH_YD |=> ph_q == PH_UPD);
  // R8: no new operand set is taken while busy
  a_r8_no_load_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !load);
endmodule

// File: rtl/euler_dp.sv
module euler_dp
  import euler_pkg::*;
#(
  parameter int W    = 16,
  parameter int FRAC = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  phase_t       phase,
  input  logic         load,
  input  logic [W-1:0] x_in,
  input  logic [W-1:0] y_in,
  input  logic [W-1:0] u_in,
  input  logic [W-1:0] dx_in,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] y_res,
  output logic         cont
);
  logic signed [W-1:0] x_q, y_q, u_q, dx_q, a_q;
  logic signed [W-1:0] ud_q, xud_q, yd_q;
  logic signed [W-1:0] mul_a, mul_b, mul_p;
  logic signed [W-1:0] x_nx, u_nx, y_nx, xud3, yd3;

  always_comb begin
    unique case (phase)
      PH_XUD:  begin mul_a = x_q; mul_b = ud_q; end
      PH_YD:   begin mul_a = y_q; mul_b = dx_q; end
      default: begin mul_a = u_q; mul_b = dx_q; end
    endcase
  end

  euler_mul #(.W(W), .FRAC(FRAC)) mul_i (
    .op_a(mul_a),
    .op_b(mul_b),
    .prod(mul_p)
  );

  assign xud3 = xud_q + (xud_q <<< 1);
  assign yd3  = yd_q + (yd_q <<< 1);
  assign x_nx = x_q + dx_q;
  assign u_nx = u_q - xud3 - yd3;
  assign y_nx = y_q + ud_q;
  assign cont = (x_nx < a_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_q <= '0; y_q <= '0; u_q <= '0; dx_q <= '0; a_q <= '0;
      ud_q <= '0; xud_q <= '0; yd_q <= '0;
    end else if (load) begin
      x_q  <= x_in;
      y_q  <= y_in;
      u_q  <= u_in;
      dx_q <= dx_in;
      a_q  <= a_in;
    end else begin
      unique case (phase)
        PH_UD:  ud_q  <= mul_p;
        PH_XUD: xud_q <= mul_p;
        PH_YD:  yd_q  <= mul_p;
        PH_UPD: begin
          x_q <= x_nx;
          u_q <= u_nx;
          y_q <= y_nx;
        end
        default: ;
      endcase
    end
  end

  assign y_res = y_q;

  // R3: x advances by one step at each commit
  a_r3_x_step: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_UPD |=> x_q == $past(x_q) + $past(dx_q));
  // R4: y takes the u*dx product at each commit
  a_r4_y_step: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_UPD |=> y_q == $past(y_q) + $past(ud_q));
  // R2: step and bound change only on capture
  a_r2_ops_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(dx_q) && $stable(a_q));
  // R4: state is untouched outside the commit step
  a_r4_state_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && phase != PH_UPD) |=> $stable(x_q) && $stable(y_q) && $stable(u_q));
endmodule

// File: rtl/euler_solver.sv
module euler_solver
  import euler_pkg::*;
#(
  parameter int W    = 16,
  parameter int FRAC = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] x_in,
  input  logic [W-1:0] y_in,
  input  logic [W-1:0] u_in,
  input  logic [W-1:0] dx_in,
  input  logic [W-1:0] a_in,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] y_out,
  output logic         busy
);
  phase_t phase;
  logic   load, cont;

  euler_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_ready(out_ready),
    .cont(cont), .phase(phase), .load(load), .in_ready(in_ready),
    .out_valid(out_valid), .busy(busy)
  );

  euler_dp #(.W(W), .FRAC(FRAC)) dp_i (
    .clk(clk), .rst_n(rst_n), .phase(phase), .load(load),
    .x_in(x_in), .y_in(y_in), .u_in(u_in), .dx_in(dx_in), .a_in(a_in),
    .y_res(y_out), .cont(cont)
  );

  // R7: a stalled result is held
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(y_out));
  // R5: the loop ends only when the fresh x failed the bound test
  a_r5_exit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(!cont));
  // R9: a consumed result frees the engine
  a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |=> !busy && in_ready);
endmodule

// File: tb/euler_solver_tb_top.sv
module euler_solver_tb_top;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [W-1:0] x_in = '0, y_in = '0, u_in = '0, dx_in = '0, a_in = '0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [W-1:0] y_out;
  logic         busy;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;

  typedef struct {
    shortint y;
    int      n;
    int      hold;
    int      acc;
  } exp_t;
  exp_t sb[$];

  euler_solver dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .x_in(x_in), .y_in(y_in), .u_in(u_in), .dx_in(dx_in), .a_in(a_in),
    .out_valid(out_valid), .out_ready(out_ready), .y_out(y_out), .busy(busy)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  function automatic shortint fmul(input shortint a, input shortint b);
    longint p;
    p = longint'(a) * longint'(b);
    p = p >>> 8;
    return shortint'(p);
  endfunction

  // driver: compute reference, offer operands, record acceptance
  task automatic send(input shortint x0, input shortint y0, input shortint u0,
                      input shortint dx, input shortint a, input int hold,
                      input bit poke_busy);
    shortint x, y, u, p, q, r;
    exp_t e;
    x = x0; y = y0; u = u0; e.n = 0;
    do begin
      p = fmul(u, dx);
      q = fmul(x, p);
      r = fmul(y, dx);
      u = shortint'(int'(u) - 3 * int'(q) - 3 * int'(r));
      y = shortint'(int'(y) + int'(p));
      x = shortint'(int'(x) + int'(dx));
      e.n++;
    end while (x < a);
    e.y = y; e.hold = hold;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    x_in = x0; y_in = y0; u_in = u0; dx_in = dx; a_in = a;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    e.acc = cyc;
    sb.push_back(e);
    if (poke_busy) begin
      for (int k = 0; k < 3; k++) begin
        in_valid = 1'b1;
        x_in = 16'h1234; y_in = 16'h7F00; u_in = 16'h8001; dx_in = 16'h0001; a_in = 16'h0002;
        check(in_ready == 1'b0, "R8 in_ready low while busy", int'(in_ready), 0);
        check(busy == 1'b1, "R9 busy after acceptance", int'(busy), 1);
        @(negedge clk);
      end
      in_valid = 1'b0;
    end
  endtask

  // monitor: pop and compare as results appear
  bit      seen = 0;
  int      hold_left = 0;
  logic [W-1:0] y_first;
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (sb.size() == 0) begin
        check(1'b0, "R6 unexpected result", int'(y_out), 0);
      end else begin
        if (!seen) begin
          seen = 1;
          y_first = y_out;
          hold_left = sb[0].hold;
          check(cyc == sb[0].acc + 4 * sb[0].n, "R6 result latency",
                cyc - sb[0].acc, 4 * sb[0].n);
        end else begin
          check(y_out == y_first, "R7 y_out held during stall",
                int'($signed(y_out)), int'($signed(y_first)));
        end
        check(busy == 1'b1, "R9 busy while result pending", int'(busy), 1);
        if (hold_left > 0) begin
          out_ready = 1'b0;
          hold_left--;
        end else begin
          out_ready = 1'b1;
          check(y_out == W'(sb[0].y), "R4 R5 final y",
                int'($signed(y_out)), int'(sb[0].y));
          void'(sb.pop_front());
          seen = 0;
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(in_ready == 1'b1, "R1 in_ready in reset", int'(in_ready), 1);
    check(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
    check(busy == 1'b0, "R1 busy in reset", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1 && busy == 1'b0 && out_valid == 1'b0,
          "R1 idle after reset", int'({in_ready, busy, out_valid}), 4);
    // R3 R5: bound reached exactly after 8 steps
    send(16'sd0, 16'sd256, 16'sd0, 16'sd32, 16'sd256, 0, 1'b0);
    // R2 R4: nonzero u, two passes
    send(16'sd0, 16'sd0, 16'sd256, 16'sd64, 16'sd128, 2, 1'b1);
    // R5: x already past the bound still makes one pass
    send(16'sd512, 16'sd100, 16'sd40, 16'sd16, 16'sd256, 0, 1'b0);
    // R4: negative operands
    send(-16'sd256, -16'sd128, 16'sd100, 16'sd16, 16'sd0, 1, 1'b1);
    // R7: stalled output with negative u
    send(16'sd0, 16'sd100, -16'sd300, 16'sd8, 16'sd64, 4, 1'b0);
    // R4: large values wrap modulo 2^16
    send(16'sd0, 16'sd1000, 16'sd2000, 16'sd128, 16'sd2560, 0, 1'b0);
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
    check(busy == 1'b0 && in_ready == 1'b1, "R9 idle after last result",
          int'({busy, in_ready}), 1);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule